// File: doc/BRIEF.md
# Per-Client Traffic Fence and Hot Reset

This block sits in a memory controller between 15 client request lines and the arbiter. Each client has a run-enable bit. While that bit is clear, the client's new requests are fenced off: they get no grant, but the client is expected to keep the request up. Transactions that were already granted still drain. Each client also has a hot-reset bit that drives an active-low reset line out to the client.

A small outstanding-transaction counter per client goes up on every grant and down on every completion. Software fences a client by clearing its enable bit. It then polls that client's counter until it reads zero, and only then pulses the reset bit low. All state is reached through one register port that writes on a strobe and reads combinationally.

Register map (word addresses): 0 holds the run-enable bits, 1 holds the hot-reset bits, and 2 to 16 hold the outstanding counts of clients 0 to 14. In the enable and reset registers, client i uses bit i.

Top module: `client_fence_ctrl`

## Requirements
- R1: After power-on reset, the enable and reset registers read 0x7FFF, and every outstanding count reads zero.
- R2: A write with `reg_we` high to address 0 or 1 loads that register from bits 14:0 of `reg_wdata` on the next clock edge. Bits above 14 are dropped and read back as zero.
- R3: `cli_gnt[i]` is high in the same cycle as `cli_req[i]` when enable bit i is set and count i is below its maximum.
- R4: While enable bit i is clear, `cli_gnt[i]` stays low whatever `cli_req[i]` does. A request still held when the bit is set again is granted in the cycle after the write.
- R5: Count i rises by one on each clock edge with a grant and no completion. It falls by one on an edge with a completion and no grant. It is unchanged when both occur and the count is non-zero.
- R6: A completion that arrives while count i is zero is ignored, so the count never wraps below zero.
- R7: Count i saturates at 15. While it is at 15, no grant is given to client i.
- R8: Completions keep draining count i while client i is fenced.
- R9: `cli_rst_n[i]` follows reset bit i. Clearing the bit holds client i in reset (the line reads 0), and setting the bit releases it.
- R10: Reads from addresses 17 to 31 return zero. The outstanding counts appear in bits 3:0 of their words, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| cli_req | input | 15 | Per-client request, held until granted |
| cli_gnt | output | 15 | Per-client grant, passed on to the arbiter |
| cli_done | input | 15 | Per-client completion pulse |
| cli_rst_n | output | 15 | Per-client hot reset, active low |

## Verification
The assertions assume that `cli_done` pulses only for transactions that were granted earlier. A stray completion at zero is still allowed, because the block must ignore it. They also assume that register writes aimed at addresses 0 and 1 carry meaningful data in bits 14:0. The stimulus includes stray completions on idle clients, to exercise the ignore case. Requests are held across a fence, and a single request is kept up long enough to push its counter to saturation. The bench's reference model tracks each counter as an integer and predicts the grants and the read data for every cycle.

// File: rtl/client_fence_ctrl.sv
module client_fence_ctrl #(
  parameter int N  = 15,
  parameter int CW = 4,
  parameter int DW = 32,
  parameter int AW = $clog2(N + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [N-1:0]  cli_req,
  output logic [N-1:0]  cli_gnt,
  input  logic [N-1:0]  cli_done,
  output logic [N-1:0]  cli_rst_n
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [AW-1:0] A_EN = AW'(0);
  localparam logic [AW-1:0] A_RS = AW'(1);

  logic [N-1:0]         en_q, rs_q;
  logic [N-1:0][CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '1;
      rs_q <= '1;
    end else if (reg_we) begin
      if (reg_addr == A_EN) en_q <= reg_wdata[N-1:0];
      if (reg_addr == A_RS) rs_q <= reg_wdata[N-1:0];
    end
  end

  assign cli_rst_n = rs_q;

  for (genvar i = 0; i < N; i++) begin : g_cli
    logic drain;
    assign cli_gnt[i] = cli_req[i] & en_q[i] & (cnt_q[i] != CMAX);
    assign drain      = cli_done[i] & (cnt_q[i] != '0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q[i] <= '0;
      else if (cli_gnt[i] & !drain) cnt_q[i] <= cnt_q[i] + 1'b1;
      else if (!cli_gnt[i] & drain) cnt_q[i] <= cnt_q[i] - 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_EN) reg_rdata[N-1:0] = en_q;
    if (reg_addr == A_RS) reg_rdata[N-1:0] = rs_q;
    for (int i = 0; i < N; i++)
      if (reg_addr == AW'(i + 2)) reg_rdata[CW-1:0] = cnt_q[i];
  end
endmodule

// File: rtl/client_fence_chk.sv
module client_fence_chk #(
  parameter int N  = 15,
  parameter int CW = 4,
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [AW-1:0]        reg_addr,
  input logic [DW-1:0]        reg_wdata,
  input logic [N-1:0]         cli_req,
  input logic [N-1:0]         cli_gnt,
  input logic [N-1:0]         cli_done,
  input logic [N-1:0]         cli_rst_n,
  input logic [N-1:0]         en_q,
  input logic [N-1:0][CW-1:0] cnt_q
);
  localparam logic [CW-1:0] CMAX = '1;

  p_rst_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(1)) |=> cli_rst_n == $past(reg_wdata[N-1:0]));

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_fenced_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[i] |-> !cli_gnt[i]);
    p_gnt_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cli_gnt[i] |-> cli_req[i]);
    p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cli_gnt[i] && !cli_done[i]) |=> cnt_q[i] == CW'($past(cnt_q[i]) + 1'b1));
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i] == '0 && !cli_gnt[i]) |=> cnt_q[i] == '0);
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[i] == CMAX |-> !cli_gnt[i]);
    p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cli_gnt[i] && cli_done[i] && cnt_q[i] != '0) |=> cnt_q[i] == CW'($past(cnt_q[i]) - 1'b1));
  end
endmodule

bind client_fence_ctrl client_fence_chk #(.N(N), .CW(CW), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cli_req(cli_req), .cli_gnt(cli_gnt),
  .cli_done(cli_done), .cli_rst_n(cli_rst_n), .en_q(en_q), .cnt_q(cnt_q)
);

// File: tb/client_fence_ctrl_tb.sv
module client_fence_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, reg_we = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [14:0] cli_req = 0, cli_gnt, cli_done = 0, cli_rst_n;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int en_m, rs_m;
  int cnt_m [15];

  always #(CLK_PERIOD/2) clk = ~clk;

  client_fence_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cli_req(cli_req),
    .cli_gnt(cli_gnt), .cli_done(cli_done), .cli_rst_n(cli_rst_n)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [14:0] rq, input logic [14:0] dn, input logic we,
                      input logic [4:0] ad, input logic [31:0] wd, input string tag);
    int eg, er;
    cli_req = rq; cli_done = dn; reg_we = we; reg_addr = ad; reg_wdata = wd;
    #1;
    eg = 0;
    for (int i = 0; i < 15; i++)
      if (rq[i] && en_m[i] && cnt_m[i] < 15) eg |= (1 << i);
    if (ad == 0) er = en_m;
    else if (ad == 1) er = rs_m;
    else if (ad >= 2 && ad <= 16) er = cnt_m[ad - 2];
    else er = 0;
    check(tag, "cli_gnt", int'(cli_gnt), eg);
    check(tag, "cli_rst_n", int'(cli_rst_n), rs_m);
    check(tag, "reg_rdata", int'(reg_rdata), er);
    @(posedge clk);
    for (int i = 0; i < 15; i++)
      cnt_m[i] = cnt_m[i] + (eg >> i & 1) - ((dn[i] && cnt_m[i] > 0) ? 1 : 0);
    if (we && ad == 0) en_m = int'(wd[14:0]);
    if (we && ad == 1) rs_m = int'(wd[14:0]);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    en_m = 32'h7FFF; rs_m = 32'h7FFF;
    foreach (cnt_m[i]) cnt_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    step(0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 0, "R1");
    step(0, 0, 0, 9, 0, "R1");
    repeat (3) step(15'h0001, 0, 0, 2, 0, "R5");
    step(0, 15'h0001, 0, 2, 0, "R5");
    step(15'h0001, 15'h0001, 0, 2, 0, "R5");
    step(0, 15'h0008, 0, 5, 0, "R6");
    step(0, 15'h0008, 0, 5, 0, "R6");
    step(0, 0, 1, 0, 32'hFFFF_7FFE, "R2");
    step(0, 0, 0, 0, 0, "R2");
    repeat (2) step(15'h0001, 0, 0, 2, 0, "R4");
    repeat (4) step(15'h0001, 15'h0001, 0, 2, 0, "R8");
    step(15'h0001, 0, 1, 0, 32'h0000_7FFF, "R4");
    step(15'h0001, 0, 0, 2, 0, "R4");
    repeat (18) step(15'h0020, 0, 0, 7, 0, "R7");
    step(15'h0020, 15'h0020, 0, 7, 0, "R7");
    step(15'h0020, 0, 0, 7, 0, "R7");
    step(0, 0, 1, 1, 32'h0000_7FFB, "R9");
    step(0, 0, 0, 1, 0, "R9");
    step(0, 0, 1, 1, 32'hFFFF_FFFF, "R9");
    step(0, 0, 0, 1, 0, "R9");
    step(0, 0, 0, 20, 0, "R10");
    step(0, 0, 0, 31, 0, "R10");
    step(15'h7FFF, 0, 0, 16, 0, "R3");
    step(15'h5555, 15'h2AAA, 0, 12, 0, "R3");
    step(0, 15'h7FFF, 0, 7, 0, "R10");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule